// File: doc/BRIEF.md
# Parity-Guarded Scratchpad with Replica Repair

This block is a word-addressed data scratchpad that keeps one even-parity bit per group of data bits next to every stored word. Parity only detects a fault. Correction comes from a copy held elsewhere. Lines the core has written (dirty) have their copy in the data cache. Lines that were last loaded from lower memory (clean) are fetched again from that lower memory. When a read hits a word whose parity is wrong, a three-state sequencer stalls the requester and asks the replica port for the word. It then rewrites the word with fresh parity and lets the held read complete with the repaired value.

The block also holds the cacheable decision for the system address map. Program ROM (0x00000000–0x1FFFFFFF) and RAM (0x40000000–0x7FFFFFFF) are cacheable, and I/O (0x20000000–0x3FFFFFFF) is not. The scratchpad window is 0x8E000000–0x8FFFFFFF. Writes into that window are forced cacheable, so the cache builds the replica, while reads from it stay uncached. With the recovery-mode input raised, scratchpad writes are also flagged for write-through.

The sequencer states are ST_IDLE, ST_FETCH and ST_REPAIR.
- In ST_IDLE, a clean access is served. A read that fails parity goes to ST_FETCH.
- In ST_FETCH, the replica request is held until rep_ack. rep_ack moves the sequencer to ST_REPAIR.
- In ST_REPAIR, the word is rewritten for one cycle, and the sequencer always returns to ST_IDLE.

Top module: `pspm_top`

## Requirements
- R1: A write accepted at a clock edge stores its data. A read accepted at an edge raises rd_valid in the next cycle, with rd_data equal to the stored word. The word index is acc_addr bits [7:2] with the default parameters.
- R2: Each parity group is stored with even parity. A read of a word with an odd number of flipped bits in a group raises parity_alarm and acc_stall in the same cycle. An even number of flips within one group goes undetected, and the corrupted data is returned.
- R3: In ST_IDLE, a scratchpad read whose parity is correct never sees acc_stall and completes one cycle later.
- R4: The cycle after a detection, rep_req is high and rep_word equals the failing word index. rep_from_cache equals the dirty bit of that word's line. rep_req and rep_word hold steady until rep_ack.
- R5: After rep_ack, one ST_REPAIR cycle rewrites the word with rep_data and fresh parity. The held read then completes with the replica data, and later reads of that word are clean.
- R6: A line is LINE_WORDS consecutive words (4 by default) with one shared dirty bit. A write with acc_fill=0 sets the bit, and a write with acc_fill=1 clears it.
- R7: While in ST_FETCH or ST_REPAIR, parity_alarm is high and every scratchpad request is stalled. A write held through the recovery lands after it and overrides the replica.
- R8: cacheable is high for enabled program ROM and RAM accesses and for scratchpad writes. It is low for I/O accesses and scratchpad reads.
- R9: write_through is high only for an enabled scratchpad write while rec_mode is high.
- R10: Accesses outside the scratchpad window are never stalled and produce no rd_valid.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| acc_en | input | 1 | Access request |
| acc_wr | input | 1 | 1 = write, 0 = read |
| acc_fill | input | 1 | Write is a line load from lower memory (clears dirty) |
| acc_addr | input | ADDR_W | Byte address in the system map |
| acc_wdata | input | DATA_W | Write data |
| rec_mode | input | 1 | Error-recovery mode for write-through marking |
| acc_stall | output | 1 | Request not taken; hold it |
| rd_valid | output | 1 | Read data valid |
| rd_data | output | DATA_W | Read data |
| parity_alarm | output | 1 | Parity failure seen or recovery in progress |
| cacheable | output | 1 | Final cacheable decision |
| write_through | output | 1 | Scratchpad write to be written through |
| rep_req | output | 1 | Replica request |
| rep_from_cache | output | 1 | 1 = replica from data cache, 0 = from lower memory |
| rep_word | output | log2(DEPTH) | Word index being repaired |
| rep_ack | input | 1 | Replica data present |
| rep_data | input | DATA_W | Replica word |

## Verification
The bench injects upsets into the stored bits and goes after the following corners.

- **Fault patterns.** It flips one data bit, three data bits, the parity bit alone and two bits. A checker that inverted the parity sense would flag every clean read. One that ignored the parity bit would miss the parity-only upset.
- **Line-shared dirty bit.** It writes one word of a line without fill and a later word of the same line with fill, then expects the replica to come from lower memory. A per-word or never-cleared dirty bit would point the request at the cache.
- **Slow replica and held write.** It delays rep_ack for several cycles and holds a write to the word under repair through the recovery. A sequencer that dropped rep_req early, or that let the replica overwrite the newer write, shows up as wrong rep_req or wrong read data.

// File: rtl/pspm_pkg.sv
package pspm_pkg;

    typedef enum logic [1:0] {
        ST_IDLE   = 2'd0,
        ST_FETCH  = 2'd1,
        ST_REPAIR = 2'd2
    } rec_state_t;

    // System address map (32-bit byte addresses)
    localparam logic [31:0] MAP_ROM_HI = 32'h1FFF_FFFF;
    localparam logic [31:0] MAP_RAM_LO = 32'h4000_0000;
    localparam logic [31:0] MAP_RAM_HI = 32'h7FFF_FFFF;
    localparam logic [31:0] MAP_SPM_LO = 32'h8E00_0000;
    localparam logic [31:0] MAP_SPM_HI = 32'h8FFF_FFFF;

endpackage

// File: rtl/pspm_cache_decide.sv
module pspm_cache_decide
    import pspm_pkg::*;
#(
    parameter int ADDR_W = 32
) (
    input  logic              en,
    input  logic              wr,
    input  logic [ADDR_W-1:0] addr,
    input  logic              rec_mode,
    output logic              in_spm,
    output logic              cacheable,
    output logic              write_through
);
    logic [31:0] a32;
    logic        is_rom;
    logic        is_ram;

    assign a32    = 32'(addr);
    assign is_rom = (a32 <= MAP_ROM_HI);
    assign is_ram = (a32 >= MAP_RAM_LO) && (a32 <= MAP_RAM_HI);
    assign in_spm = (a32 >= MAP_SPM_LO) && (a32 <= MAP_SPM_HI);

    // Ordinary map decision ORed with the scratchpad-write unit
    assign cacheable     = en && (is_rom || is_ram || (in_spm && wr));
    assign write_through = en && in_spm && wr && rec_mode;

    always_comb begin
        if (en && in_spm && !wr) begin
            assert_spm_read_uncached_R8: assert (!cacheable);
        end
        if (write_through) begin
            assert_wt_implies_cacheable_R9: assert (cacheable && wr);
        end
    end
endmodule

// File: rtl/pspm_store.sv
module pspm_store #(
    parameter int DATA_W     = 32,
    parameter int PAR_W      = 1,
    parameter int DEPTH      = 64,
    parameter int LINE_WORDS = 4
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     wr_en,
    input  logic                     wr_fill,
    input  logic [$clog2(DEPTH)-1:0] wr_idx,
    input  logic [DATA_W-1:0]        wr_data,
    input  logic                     fix_en,
    input  logic [$clog2(DEPTH)-1:0] fix_idx,
    input  logic [DATA_W-1:0]        fix_data,
    input  logic [$clog2(DEPTH)-1:0] rd_idx,
    output logic [DATA_W-1:0]        rd_data,
    output logic                     rd_bad,
    output logic                     rd_dirty
);
    localparam int IDX_W  = $clog2(DEPTH);
    localparam int OFS_W  = $clog2(LINE_WORDS);
    localparam int LINES  = DEPTH / LINE_WORDS;
    localparam int LINE_W = IDX_W - OFS_W;
    localparam int GRP_W  = DATA_W / PAR_W;
    localparam int WORD_W = DATA_W + PAR_W;

    function automatic logic [PAR_W-1:0] even_par(input logic [DATA_W-1:0] d);
        logic [PAR_W-1:0] p;
        for (int g = 0; g < PAR_W; g++) begin
            p[g] = ^d[g*GRP_W +: GRP_W];
        end
        return p;
    endfunction

    logic [WORD_W-1:0] mem_q   [DEPTH];
    logic [LINES-1:0]  dirty_q;
    logic [WORD_W-1:0] rd_word;
    logic [LINE_W-1:0] wr_line;

    assign wr_line = wr_idx[IDX_W-1:OFS_W];

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < DEPTH; i++) begin
                mem_q[i] <= '0;
            end
        end else begin
            if (wr_en) begin
                mem_q[wr_idx] <= {even_par(wr_data), wr_data};
            end
            if (fix_en) begin
                mem_q[fix_idx] <= {even_par(fix_data), fix_data};
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            dirty_q <= '0;
        end else if (wr_en) begin
            dirty_q[wr_line] <= !wr_fill;
        end
    end

    assign rd_word  = mem_q[rd_idx];
    assign rd_data  = rd_word[DATA_W-1:0];
    assign rd_bad   = |(even_par(rd_data) ^ rd_word[DATA_W +: PAR_W]);
    assign rd_dirty = dirty_q[rd_idx[IDX_W-1:OFS_W]];

    assert_dirty_tracks_fill_R6: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |=> (dirty_q[$past(wr_line)] == !$past(wr_fill)));

endmodule

// File: rtl/pspm_recover_fsm.sv
module pspm_recover_fsm
    import pspm_pkg::*;
#(
    parameter int DATA_W = 32,
    parameter int IDX_W  = 6
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_read,
    input  logic              req_write,
    input  logic [IDX_W-1:0]  req_idx,
    input  logic [DATA_W-1:0] rd_word,
    input  logic              rd_bad,
    input  logic              rd_dirty,
    input  logic              rep_ack,
    input  logic [DATA_W-1:0] rep_data,
    output logic              stall,
    output logic              alarm,
    output logic              wr_go,
    output logic              rep_req,
    output logic              rep_from_cache,
    output logic [IDX_W-1:0]  rep_word,
    output logic              fix_en,
    output logic [IDX_W-1:0]  fix_idx,
    output logic [DATA_W-1:0] fix_data,
    output logic              rd_valid,
    output logic [DATA_W-1:0] rd_data
);
    rec_state_t        state_q, state_d;
    logic              rd_go;
    logic [IDX_W-1:0]  rec_idx_q;
    logic              rec_cache_q;
    logic [DATA_W-1:0] fix_data_q;
    logic              rd_valid_q;
    logic [DATA_W-1:0] rd_data_q;

    // State and data registers
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q     <= ST_IDLE;
            rec_idx_q   <= '0;
            rec_cache_q <= 1'b0;
            fix_data_q  <= '0;
            rd_valid_q  <= 1'b0;
            rd_data_q   <= '0;
        end else begin
            state_q    <= state_d;
            rd_valid_q <= rd_go;
            if (rd_go) begin
                rd_data_q <= rd_word;
            end
            if (state_q == ST_IDLE && req_read && rd_bad) begin
                rec_idx_q   <= req_idx;
                rec_cache_q <= rd_dirty;
            end
            if (state_q == ST_FETCH && rep_ack) begin
                fix_data_q <= rep_data;
            end
        end
    end

    // Next state and outputs
    always_comb begin
        state_d = state_q;
        stall   = 1'b0;
        alarm   = 1'b0;
        wr_go   = 1'b0;
        rd_go   = 1'b0;
        rep_req = 1'b0;
        fix_en  = 1'b0;
        unique case (state_q)
            ST_IDLE: begin
                if (req_read && rd_bad) begin
                    stall   = 1'b1;
                    alarm   = 1'b1;
                    state_d = ST_FETCH;
                end else begin
                    rd_go = req_read;
                    wr_go = req_write;
                end
            end
            ST_FETCH: begin
                stall   = req_read || req_write;
                alarm   = 1'b1;
                rep_req = 1'b1;
                if (rep_ack) begin
                    state_d = ST_REPAIR;
                end
            end
            ST_REPAIR: begin
                stall   = req_read || req_write;
                alarm   = 1'b1;
                fix_en  = 1'b1;
                state_d = ST_IDLE;
            end
            default: state_d = ST_IDLE;
        endcase
    end

    assign rep_from_cache = rec_cache_q;
    assign rep_word       = rec_idx_q;
    assign fix_idx        = rec_idx_q;
    assign fix_data       = fix_data_q;
    assign rd_valid       = rd_valid_q;
    assign rd_data        = rd_data_q;

    assert_detect_raises_req_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_IDLE && req_read && rd_bad) |=>
            (rep_req && rep_word == $past(req_idx) && rep_from_cache == $past(rd_dirty)));

    assert_req_held_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (rep_req && !rep_ack) |=> (rep_req && $stable(rep_word)));

    assert_ack_to_repair_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (rep_req && rep_ack) |=> (fix_en && !rep_req && fix_data == $past(rep_data)));

    assert_clean_read_served_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_IDLE && req_read && !rd_bad) |-> (!stall ##1 (rd_valid && rd_data == $past(rd_word))));

    assert_no_write_in_recovery_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (rep_req || fix_en) |-> (!wr_go && alarm));

endmodule

// File: rtl/pspm_top.sv
module pspm_top #(
    parameter int ADDR_W     = 32,
    parameter int DATA_W     = 32,
    parameter int PAR_W      = 1,
    parameter int DEPTH      = 64,
    parameter int LINE_WORDS = 4
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     acc_en,
    input  logic                     acc_wr,
    input  logic                     acc_fill,
    input  logic [ADDR_W-1:0]        acc_addr,
    input  logic [DATA_W-1:0]        acc_wdata,
    input  logic                     rec_mode,
    output logic                     acc_stall,
    output logic                     rd_valid,
    output logic [DATA_W-1:0]        rd_data,
    output logic                     parity_alarm,
    output logic                     cacheable,
    output logic                     write_through,
    output logic                     rep_req,
    output logic                     rep_from_cache,
    output logic [$clog2(DEPTH)-1:0] rep_word,
    input  logic                     rep_ack,
    input  logic [DATA_W-1:0]        rep_data
);
    localparam int IDX_W   = $clog2(DEPTH);
    localparam int BYTE_LS = $clog2(DATA_W / 8);

    logic              in_spm;
    logic              req_read;
    logic              req_write;
    logic [IDX_W-1:0]  req_idx;
    logic              wr_go;
    logic              fix_en;
    logic [IDX_W-1:0]  fix_idx;
    logic [DATA_W-1:0] fix_data;
    logic [DATA_W-1:0] word_q;
    logic              word_bad;
    logic              word_dirty;

    assign req_read  = acc_en && in_spm && !acc_wr;
    assign req_write = acc_en && in_spm && acc_wr;
    assign req_idx   = acc_addr[BYTE_LS +: IDX_W];

    pspm_cache_decide #(.ADDR_W(ADDR_W)) u_decide (
        .en            (acc_en),
        .wr            (acc_wr),
        .addr          (acc_addr),
        .rec_mode      (rec_mode),
        .in_spm        (in_spm),
        .cacheable     (cacheable),
        .write_through (write_through)
    );

    pspm_store #(
        .DATA_W(DATA_W), .PAR_W(PAR_W), .DEPTH(DEPTH), .LINE_WORDS(LINE_WORDS)
    ) u_store (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_en    (wr_go),
        .wr_fill  (acc_fill),
        .wr_idx   (req_idx),
        .wr_data  (acc_wdata),
        .fix_en   (fix_en),
        .fix_idx  (fix_idx),
        .fix_data (fix_data),
        .rd_idx   (req_idx),
        .rd_data  (word_q),
        .rd_bad   (word_bad),
        .rd_dirty (word_dirty)
    );

    pspm_recover_fsm #(.DATA_W(DATA_W), .IDX_W(IDX_W)) u_fsm (
        .clk            (clk),
        .rst_n          (rst_n),
        .req_read       (req_read),
        .req_write      (req_write),
        .req_idx        (req_idx),
        .rd_word        (word_q),
        .rd_bad         (word_bad),
        .rd_dirty       (word_dirty),
        .rep_ack        (rep_ack),
        .rep_data       (rep_data),
        .stall          (acc_stall),
        .alarm          (parity_alarm),
        .wr_go          (wr_go),
        .rep_req        (rep_req),
        .rep_from_cache (rep_from_cache),
        .rep_word       (rep_word),
        .fix_en         (fix_en),
        .fix_idx        (fix_idx),
        .fix_data       (fix_data),
        .rd_valid       (rd_valid),
        .rd_data        (rd_data)
    );

    assert_outside_never_stalls_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (acc_en && !in_spm) |-> (!acc_stall ##1 !rd_valid));

endmodule

// File: tb/pspm_top_tb_top.sv
module pspm_top_tb_top;
    localparam int DW = 32;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        acc_en = 1'b0, acc_wr = 1'b0, acc_fill = 1'b0, rec_mode = 1'b0;
    logic [31:0] acc_addr = '0, acc_wdata = '0;
    logic        acc_stall, rd_valid, parity_alarm, cacheable, write_through;
    logic        rep_req, rep_from_cache;
    logic [5:0]  rep_word;
    logic        rep_ack = 1'b0;
    logic [31:0] rep_data = '0;
    logic [DW-1:0] rd_data;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    always #5 clk = ~clk;

    pspm_top dut_i (
        .clk(clk), .rst_n(rst_n), .acc_en(acc_en), .acc_wr(acc_wr), .acc_fill(acc_fill),
        .acc_addr(acc_addr), .acc_wdata(acc_wdata), .rec_mode(rec_mode),
        .acc_stall(acc_stall), .rd_valid(rd_valid), .rd_data(rd_data),
        .parity_alarm(parity_alarm), .cacheable(cacheable), .write_through(write_through),
        .rep_req(rep_req), .rep_from_cache(rep_from_cache), .rep_word(rep_word),
        .rep_ack(rep_ack), .rep_data(rep_data)
    );

    typedef struct packed {
        logic        wr;
        logic        fill;
        logic [5:0]  idx;
        logic [31:0] data;
    } vec_t;

    // Word 0 unfilled then word 3 filled: line 0 ends clean (R6)
    localparam vec_t VECS [8] = '{
        '{wr: 1'b1, fill: 1'b0, idx: 6'd0,  data: 32'hA5A5_5A5A},
        '{wr: 1'b1, fill: 1'b1, idx: 6'd3,  data: 32'h1234_5678},
        '{wr: 1'b1, fill: 1'b0, idx: 6'd63, data: 32'hFFFF_FFFF},
        '{wr: 1'b1, fill: 1'b0, idx: 6'd4,  data: 32'h0000_0000},
        '{wr: 1'b0, fill: 1'b0, idx: 6'd0,  data: 32'hA5A5_5A5A},
        '{wr: 1'b0, fill: 1'b0, idx: 6'd3,  data: 32'h1234_5678},
        '{wr: 1'b0, fill: 1'b0, idx: 6'd63, data: 32'hFFFF_FFFF},
        '{wr: 1'b0, fill: 1'b0, idx: 6'd4,  data: 32'h0000_0000}
    };

    function automatic logic [31:0] spm(input int idx);
        return 32'h8E00_0000 + 32'(idx * 4);
    endfunction

    task automatic chk(input bit ok, input string req, input string what,
                       input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    task automatic do_write(input int idx, input logic [31:0] d, input logic fill);
        @(negedge clk);
        acc_en = 1; acc_wr = 1; acc_fill = fill; acc_addr = spm(idx); acc_wdata = d;
        @(negedge clk);
        acc_en = 0; acc_wr = 0; acc_fill = 0;
    endtask

    task automatic do_read(input int idx, input logic [31:0] exp, input string req);
        @(negedge clk);
        acc_en = 1; acc_wr = 0; acc_addr = spm(idx);
        #1;
        chk(acc_stall == 0, "R3", "clean read stall", 64'(acc_stall), 0);
        chk(parity_alarm == 0, req, "clean read alarm", 64'(parity_alarm), 0);
        @(negedge clk);
        acc_en = 0;
        chk(rd_valid == 1, req, "rd_valid", 64'(rd_valid), 1);
        chk(rd_data == exp, req, "rd_data", 64'(rd_data), 64'(exp));
    endtask

    task automatic upset(input int idx, input logic [32:0] mask);
        dut_i.u_store.mem_q[idx] = dut_i.u_store.mem_q[idx] ^ mask;
    endtask

    task automatic recover_read(input int idx, input logic [31:0] replica,
                                input logic exp_cache, input int waits);
        @(negedge clk);
        acc_en = 1; acc_wr = 0; acc_addr = spm(idx);
        #1;
        chk(parity_alarm == 1, "R2", "alarm on upset", 64'(parity_alarm), 1);
        chk(acc_stall == 1, "R2", "stall on upset", 64'(acc_stall), 1);
        for (int w = 0; w < waits; w++) begin
            @(negedge clk);
            chk(rep_req == 1, "R4", "rep_req held", 64'(rep_req), 1);
        end
        @(negedge clk);
        chk(rep_req == 1, "R4", "rep_req", 64'(rep_req), 1);
        chk(rep_word == 6'(idx), "R4", "rep_word", 64'(rep_word), 64'(idx));
        chk(rep_from_cache == exp_cache, "R4", "rep_from_cache", 64'(rep_from_cache), 64'(exp_cache));
        chk(acc_stall == 1 && parity_alarm == 1, "R7", "stall+alarm in fetch",
            64'({acc_stall, parity_alarm}), 64'h3);
        rep_ack = 1; rep_data = replica;
        @(negedge clk);
        rep_ack = 0;
        chk(rep_req == 0 && acc_stall == 1, "R5", "repair cycle", 64'({rep_req, acc_stall}), 64'h1);
        @(negedge clk);
        chk(acc_stall == 0 && parity_alarm == 0, "R5", "back to idle",
            64'({acc_stall, parity_alarm}), 0);
        @(negedge clk);
        acc_en = 0;
        chk(rd_valid == 1 && rd_data == replica, "R5", "repaired data", 64'(rd_data), 64'(replica));
    endtask

    task automatic map_check(input logic [31:0] a, input logic wr, input logic rm,
                             input logic exp_c, input logic exp_wt, input string req);
        @(negedge clk);
        acc_en = 1; acc_wr = wr; acc_addr = a; rec_mode = rm;
        #1;
        chk(cacheable == exp_c, req, "cacheable", 64'(cacheable), 64'(exp_c));
        chk(write_through == exp_wt, "R9", "write_through", 64'(write_through), 64'(exp_wt));
        #1;
        acc_en = 0; acc_wr = 0; rec_mode = 0;
    endtask

    initial begin
        #2_000_000;
        if (!done) begin
            errors++;
            $display("FAIL watchdog all actual=timeout expected=finish");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1;
        @(negedge clk);
        chk(rd_valid == 0 && acc_stall == 0 && parity_alarm == 0 && rep_req == 0,
            "R1", "reset state", 64'({rd_valid, acc_stall, parity_alarm, rep_req}), 0);

        // Table walk (R1)
        foreach (VECS[i]) begin
            if (VECS[i].wr) do_write(int'(VECS[i].idx), VECS[i].data, VECS[i].fill);
            else            do_read(int'(VECS[i].idx), VECS[i].data, "R1");
        end

        // Address map (R8, R9)
        map_check(32'h0000_1000, 1'b0, 1'b0, 1'b1, 1'b0, "R8");
        map_check(32'h2000_0000, 1'b1, 1'b0, 1'b0, 1'b0, "R8");
        map_check(32'h7FFF_FFFC, 1'b1, 1'b0, 1'b1, 1'b0, "R8");
        map_check(spm(2),        1'b0, 1'b1, 1'b0, 1'b0, "R8");
        map_check(spm(2),        1'b1, 1'b0, 1'b1, 1'b0, "R8");
        map_check(spm(2),        1'b1, 1'b1, 1'b1, 1'b1, "R9");

        // Outside window: no stall, no rd_valid (R10)
        @(negedge clk);
        acc_en = 1; acc_wr = 0; acc_addr = 32'h4000_0000;
        #1 chk(acc_stall == 0, "R10", "outside stall", 64'(acc_stall), 0);
        @(negedge clk);
        acc_en = 0;
        chk(rd_valid == 0, "R10", "outside rd_valid", 64'(rd_valid), 0);

        // Single-bit upset, clean line 0 -> lower memory (R2, R4, R5, R6)
        upset(0, 33'h0_0000_0002);
        recover_read(0, 32'hA5A5_5A5A, 1'b0, 0);
        do_read(0, 32'hA5A5_5A5A, "R5");

        // Three-bit upset, dirty line 15, slow replica (R2, R4)
        upset(63, 33'h0_0000_0111);
        recover_read(63, 32'hFFFF_FFFF, 1'b1, 3);

        // Parity bit alone flipped, dirty line 1 (R2)
        upset(4, 33'h1_0000_0000);
        recover_read(4, 32'h0000_0000, 1'b1, 0);

        // Two flips in one group escape detection (R2)
        upset(63, 33'h0_0000_0003);
        do_read(63, 32'hFFFF_FFFC, "R2");

        // Fill clears dirty for the whole line (R6)
        do_write(9, 32'h0000_00AA, 1'b0);
        do_write(10, 32'h0000_00BB, 1'b1);
        upset(9, 33'h0_0000_0010);
        recover_read(9, 32'h0000_00AA, 1'b0, 0);

        // Write to word under repair waits and overrides replica (R7)
        do_write(8, 32'h0000_0011, 1'b0);
        upset(8, 33'h0_0000_0001);
        @(negedge clk);
        acc_en = 1; acc_wr = 0; acc_addr = spm(8);
        @(negedge clk);
        acc_wr = 1; acc_wdata = 32'hCAFE_0008;
        rep_ack = 1; rep_data = 32'h0000_0011;
        #1 chk(acc_stall == 1, "R7", "write stalled in fetch", 64'(acc_stall), 1);
        @(negedge clk);
        rep_ack = 0;
        chk(acc_stall == 1 && parity_alarm == 1, "R7", "write stalled in repair",
            64'({acc_stall, parity_alarm}), 64'h3);
        @(negedge clk);
        chk(acc_stall == 0, "R7", "write taken after repair", 64'(acc_stall), 0);
        @(negedge clk);
        acc_en = 0; acc_wr = 0;
        do_read(8, 32'hCAFE_0008, "R7");

        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule